// File: doc/BRIEF.md
# Hamming ECC Syndrome Decoder

This block judges one 512-byte NAND data chunk after it has been read. It receives two 24-bit single-error-correcting codes: the one kept in the spare area and the one computed over the data just read. It expands each code into a 32-bit word that holds two 12-bit halves. It forms the syndrome of the two words and sorts the outcome by how many syndrome bits are set. The outcomes are clean data, a correctable single data-bit error, a damaged code, an erased page, or an error that cannot be corrected.

Both codes arrive together on a valid/ready request port. One clock later the decoder shows a status code and, for a correctable error, the 9-bit byte offset and 3-bit bit index of the bad bit. The result stays in place until the next request arrives. A combinational repair port lets the data path stream bytes past the decoder with their offsets. The byte whose offset matches the reported one comes back with the faulty bit inverted.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: Each 24-bit code (byte0 in bits 7:0, byte1 in 15:8, byte2 in 23:16) is expanded into a 32-bit word. Byte0 goes to bits 7:0, the low nibble of byte2 to bits 11:8, byte1 to bits 23:16, and the high nibble of byte2 to bits 27:24. All other bits are zero. The syndrome is the XOR of the expanded stored word and the expanded computed word.
- R2: A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly 12 bits set gives status 1 (corrected). The bit index is syndrome bits 18:16 and the byte offset is syndrome bits 27:19.
- R4: A syndrome with exactly one bit set gives status 2 (code damaged, data good).
- R5: The erased case is a stored code of all ones (expanded 0x0FFF0FFF) together with a computed code of all zeros. Any syndrome weight other than 0, 1 or 12 that meets this case gives status 3 (erased, treated as good).
- R6: Every other non-zero syndrome gives status 4 (uncorrectable). This includes a stored code of all ones with a non-zero computed code.
- R7: `req_ready` is always high. `res_valid` is high for exactly the one cycle after each cycle in which a request is accepted.
- R8: While no request is accepted, the status, byte offset and bit index keep their values.
- R9: When the held status is 1 and `fix_offset` equals the held byte offset, `fix_byte_out` is `fix_byte_in` with the bit at the held bit index inverted.
- R10: In every other case `fix_byte_out` equals `fix_byte_in`.
- R11: A synchronous active-low reset clears the status to 0, the offset and index to 0, and `res_valid` to 0.
- R12: The byte offset and bit index read 0 whenever the status is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request carries a code pair |
| req_ready | output | 1 | Decoder accepts a request (always high) |
| req_stored | input | 24 | Code read from the spare area, byte0 in the low bits |
| req_computed | input | 24 | Code computed over the data read, byte0 in the low bits |
| res_valid | output | 1 | New result shown this cycle |
| res_status | output | 3 | 0 clean, 1 corrected, 2 code damaged, 3 erased, 4 uncorrectable |
| res_byte_off | output | 9 | Offset of the faulty byte within the chunk |
| res_bit_idx | output | 3 | Index of the faulty bit within that byte |
| fix_byte_in | input | 8 | Data byte presented for repair |
| fix_offset | input | 9 | Offset of the byte presented for repair |
| fix_byte_out | output | 8 | Byte after repair |

## Verification
Two things can happen in the same cycle: the repair port is still being used on the held result, and a new request is being accepted that will replace that result. The bench provokes this by sending a request for a correctable error. In the next cycle it offers a clean request while it presents the faulty byte's offset on the repair port. Just before the clock edge the port must still invert the bit chosen by the old result; just after the edge the same byte must pass through unchanged under the new clean status. Around this case, a scoreboard checks every one of the 4096 single-bit locations, all 24 single code-bit flips, double-bit errors and the erased-page pattern.

// File: rtl/ecc_dec_pkg.sv
// Package ecc_dec_pkg
// Holds the widths and result encodings that the syndrome decoder and its
// checker share. Assumes a 24-bit code made of three 8-bit bytes that
// protects a 512-byte chunk.
package ecc_dec_pkg;

    localparam int ECC_BYTE_W = 8;
    localparam int ECC_BYTES  = 3;
    localparam int CODE_W     = ECC_BYTES * ECC_BYTE_W;
    localparam int HALF_W     = ECC_BYTE_W + ECC_BYTE_W / 2;
    localparam int WORD_W     = 32;
    localparam int HI_LSB     = WORD_W / 2;
    localparam int BIT_IDX_W  = 3;
    localparam int BYTE_OFF_W = HALF_W - BIT_IDX_W;
    localparam int CNT_W      = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        ST_CLEAN   = 3'd0,
        ST_FIXED   = 3'd1,
        ST_ECC_BAD = 3'd2,
        ST_ERASED  = 3'd3,
        ST_UNCORR  = 3'd4
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e            status;
        logic [BYTE_OFF_W-1:0]  byte_off;
        logic [BIT_IDX_W-1:0]   bit_idx;
    } ecc_result_t;

endpackage

// File: rtl/ecc_repack.sv
// Module ecc_repack
// Expands one 3-byte code into a word with two 12-bit halves: byte0 and the
// low nibble of byte2 form the lower half, byte1 and the high nibble of
// byte2 form the upper half starting at WORD_W/2. All other bits are zero.
// Assumes BYTE_W is even and WORD_W/2 is at least BYTE_W + BYTE_W/2.
module ecc_repack #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 32
) (
    input  logic [3*BYTE_W-1:0] triplet,
    output logic [WORD_W-1:0]   word
);
    localparam int NIB_W  = BYTE_W / 2;
    localparam int HALF_W = BYTE_W + NIB_W;
    localparam int HI_LSB = WORD_W / 2;

    logic [BYTE_W-1:0] b0, b1, b2;

    assign b0 = triplet[0*BYTE_W +: BYTE_W];
    assign b1 = triplet[1*BYTE_W +: BYTE_W];
    assign b2 = triplet[2*BYTE_W +: BYTE_W];

    // Place the bytes and nibbles into the two halves.
    always_comb begin
        word                   = '0;
        word[0 +: HALF_W]      = {b2[NIB_W-1:0], b0};
        word[HI_LSB +: HALF_W] = {b2[BYTE_W-1:NIB_W], b1};
    end

endmodule

// File: rtl/ecc_popcount.sv
// Module ecc_popcount
// Counts the set bits of a vector, purely combinational.
// Assumes CNT_W is wide enough to hold W.
module ecc_popcount #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    // Add up the bits one by one.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end

endmodule

// File: rtl/ecc_classifier.sv
// Module ecc_classifier
// Forms the syndrome of the two expanded words and sorts it by weight:
// zero -> clean, half-width -> correctable data bit, one -> damaged code,
// erased pattern -> erased, anything else -> uncorrectable.
// Location fields are driven only for a correctable error.
module ecc_classifier
    import ecc_dec_pkg::*;
(
    input  logic [WORD_W-1:0] stored_w,
    input  logic [WORD_W-1:0] comp_w,
    output ecc_result_t       result
);
    localparam int                CORR_WEIGHT = HALF_W;
    localparam logic [WORD_W-1:0] HALF_ONES   = (WORD_W'(1) << HALF_W) - WORD_W'(1);
    localparam logic [WORD_W-1:0] ERASED_PAT  = HALF_ONES | (HALF_ONES << HI_LSB);

    logic [WORD_W-1:0] syndrome;
    logic [CNT_W-1:0]  weight;
    logic              erased_hit;

    assign syndrome   = stored_w ^ comp_w;
    assign erased_hit = (stored_w == ERASED_PAT) && (comp_w == '0);

    ecc_popcount #(.W(WORD_W), .CNT_W(CNT_W)) u_weight (
        .vec (syndrome),
        .cnt (weight)
    );

    // Pick the status from the syndrome weight and extract the location.
    always_comb begin
        result = '{status: ST_CLEAN, byte_off: '0, bit_idx: '0};
        if (syndrome == '0) begin
            result.status = ST_CLEAN;
        end else if (weight == CNT_W'(CORR_WEIGHT)) begin
            result.status   = ST_FIXED;
            result.bit_idx  = syndrome[HI_LSB +: BIT_IDX_W];
            result.byte_off = syndrome[HI_LSB + BIT_IDX_W +: BYTE_OFF_W];
        end else if (weight == CNT_W'(1)) begin
            result.status = ST_ECC_BAD;
        end else if (erased_hit) begin
            result.status = ST_ERASED;
        end else begin
            result.status = ST_UNCORR;
        end
    end

endmodule

// File: rtl/ecc_bit_repair.sv
// Module ecc_bit_repair
// Inverts one bit of a data byte when the held result says "corrected" and
// the byte's offset matches the reported offset; otherwise passes it on.
// Assumes the byte is 2**BIT_IDX_W bits wide.
module ecc_bit_repair
    import ecc_dec_pkg::*;
(
    input  ecc_result_t             held,
    input  logic [ECC_BYTE_W-1:0]   byte_in,
    input  logic [BYTE_OFF_W-1:0]   offset,
    output logic [ECC_BYTE_W-1:0]   byte_out
);
    logic hit;

    assign hit = (held.status == ST_FIXED) && (offset == held.byte_off);

    // Build the flip mask from the bit index and apply it on a hit.
    always_comb begin
        byte_out = byte_in;
        if (hit) begin
            byte_out = byte_in ^ (ECC_BYTE_W'(1) << held.bit_idx);
        end
    end

endmodule

// File: rtl/ecc_syndrome_decoder.sv
// Module ecc_syndrome_decoder (top)
// Accepts a stored/computed code pair on a valid/ready port, classifies the
// pair and holds the result from the cycle after acceptance until the next
// request. Provides a combinational byte repair port driven by the held
// result. Assumes one request per cycle at most; it never stalls.
module ecc_syndrome_decoder
    import ecc_dec_pkg::*;
#(
    parameter int P_CODE_W  = CODE_W,
    parameter int P_OFF_W   = BYTE_OFF_W,
    parameter int P_IDX_W   = BIT_IDX_W,
    parameter int P_BYTE_W  = ECC_BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [P_CODE_W-1:0]  req_stored,
    input  logic [P_CODE_W-1:0]  req_computed,
    output logic                 res_valid,
    output logic [2:0]           res_status,
    output logic [P_OFF_W-1:0]   res_byte_off,
    output logic [P_IDX_W-1:0]   res_bit_idx,
    input  logic [P_BYTE_W-1:0]  fix_byte_in,
    input  logic [P_OFF_W-1:0]   fix_offset,
    output logic [P_BYTE_W-1:0]  fix_byte_out
);
    localparam int N_CODES = 2;   // index 0 stored, index 1 computed

    logic [N_CODES-1:0][P_CODE_W-1:0] codes_in;
    logic [N_CODES-1:0][WORD_W-1:0]   words;
    ecc_result_t                      next_res;
    ecc_result_t                      held_res;
    logic                             accept;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign codes_in  = {req_computed, req_stored};

    // One expander per incoming code.
    for (genvar g = 0; g < N_CODES; g++) begin : g_repack
        ecc_repack #(.BYTE_W(ECC_BYTE_W), .WORD_W(WORD_W)) u_repack (
            .triplet (codes_in[g]),
            .word    (words[g])
        );
    end

    ecc_classifier u_classify (
        .stored_w (words[0]),
        .comp_w   (words[1]),
        .result   (next_res)
    );

    // Capture the result on acceptance; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_res  <= '{status: ST_CLEAN, byte_off: '0, bit_idx: '0};
            res_valid <= 1'b0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                held_res <= next_res;
            end
        end
    end

    assign res_status   = held_res.status;
    assign res_byte_off = held_res.byte_off;
    assign res_bit_idx  = held_res.bit_idx;

    ecc_bit_repair u_repair (
        .held     (held_res),
        .byte_in  (fix_byte_in),
        .offset   (fix_offset),
        .byte_out (fix_byte_out)
    );

endmodule

// File: rtl/ecc_syndrome_decoder_chk.sv
// Module ecc_syndrome_decoder_chk
// Checks the timing, hold, reset and repair rules at the decoder's ports.
// It is attached to every decoder instance by the bind below.
module ecc_syndrome_decoder_chk
    import ecc_dec_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   res_valid,
    input logic [2:0]             res_status,
    input logic [BYTE_OFF_W-1:0]  res_byte_off,
    input logic [BIT_IDX_W-1:0]   res_bit_idx,
    input logic [ECC_BYTE_W-1:0]  fix_byte_in,
    input logic [BYTE_OFF_W-1:0]  fix_offset,
    input logic [ECC_BYTE_W-1:0]  fix_byte_out
);

    assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !res_valid);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_status) && $stable(res_byte_off) && $stable(res_bit_idx)));

    // R6: only the five defined codes may ever appear.
    assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_status <= 3'd4);

    assert_loc_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_status != 3'd1) |-> (res_byte_off == '0 && res_bit_idx == '0));

    assert_repair_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_status != 3'd1 || fix_offset != res_byte_off) |-> (fix_byte_out == fix_byte_in));

    assert_repair_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_status == 3'd1 && fix_offset == res_byte_off) |->
            ($countones(fix_byte_out ^ fix_byte_in) == 1));

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_status == 3'd0));

endmodule

bind ecc_syndrome_decoder ecc_syndrome_decoder_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .res_valid    (res_valid),
    .res_status   (res_status),
    .res_byte_off (res_byte_off),
    .res_bit_idx  (res_bit_idx),
    .fix_byte_in  (fix_byte_in),
    .fix_offset   (fix_offset),
    .fix_byte_out (fix_byte_out)
);

// File: tb/ecc_syndrome_decoder_tb.sv
`timescale 1ns/1ps
// Bench ecc_syndrome_decoder_tb_top
// Scoreboard bench: the driver queues the expected result of each request,
// and a monitor compares them as res_valid pulses. Directed checks cover
// reset, hold, repair and the repair/new-request overlap.
module ecc_syndrome_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_stored = '0;
    logic [23:0] req_computed = '0;
    logic        res_valid;
    logic [2:0]  res_status;
    logic [8:0]  res_byte_off;
    logic [2:0]  res_bit_idx;
    logic [7:0]  fix_byte_in = '0;
    logic [8:0]  fix_offset = '0;
    logic [7:0]  fix_byte_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    ecc_syndrome_decoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_stored   (req_stored),
        .req_computed (req_computed),
        .res_valid    (res_valid),
        .res_status   (res_status),
        .res_byte_off (res_byte_off),
        .res_bit_idx  (res_bit_idx),
        .fix_byte_in  (fix_byte_in),
        .fix_offset   (fix_offset),
        .fix_byte_out (fix_byte_out)
    );

    // Record one check and report a failure.
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Undo the expansion of R1: syndrome word back to raw byte space.
    function automatic logic [23:0] word_to_raw(input logic [31:0] w);
        return {w[27:24], w[11:8], w[23:16], w[7:0]};
    endfunction

    // Syndrome word of a single data-bit error at location loc (R3).
    function automatic logic [31:0] loc_syndrome(input logic [11:0] loc);
        return {4'h0, loc, 4'h0, ~loc};
    endfunction

    // Driver: present one request at a falling edge and queue its result.
    task automatic send(input logic [23:0] st, input logic [23:0] cp,
                        input logic [2:0] es, input logic [8:0] eo, input logic [2:0] eb,
                        input string tag);
        @(negedge clk);
        req_valid    = 1'b1;
        req_stored   = st;
        req_computed = cp;
        exp_q.push_back({es, eo, eb});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", 32'(res_status), 32'hx);
            end else begin
                logic [14:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({res_status, res_byte_off, res_bit_idx} == e, t,
                      32'({res_status, res_byte_off, res_bit_idx}), 32'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] cp;
        logic [11:0] l1;
        // R11: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R11 valid in reset", 32'(res_valid), 0);
        check(res_status == 3'd0, "R11 status in reset", 32'(res_status), 0);
        check(req_ready == 1'b1, "R7 ready", 32'(req_ready), 1);
        rst_n = 1'b1;

        // R2: clean pairs.
        send(24'h123456, 24'h123456, 3'd0, 9'd0, 3'd0, "R2 clean a");
        send(24'hFFFFFF, 24'hFFFFFF, 3'd0, 9'd0, 3'd0, "R2 clean b");
        send(24'h000000, 24'h000000, 3'd0, 9'd0, 3'd0, "R2 clean c");

        // R1 R3: every single data-bit location, back to back.
        for (int l = 0; l < 4096; l++) begin
            cp = 24'hA53C96 ^ {12'(l), 12'(l * 7)};
            send(cp ^ word_to_raw(loc_syndrome(12'(l))), cp,
                 3'd1, 9'(l >> 3), 3'(l), "R3 R1 data bit");
        end

        // R4: each of the 24 code bits flipped alone.
        for (int k = 0; k < 24; k++) begin
            send(24'h5A0F33 ^ (24'd1 << k), 24'h5A0F33, 3'd2, 9'd0, 3'd0, "R4 code bit");
        end

        // R6: double data-bit errors (syndrome weight never 12 here).
        for (int k = 0; k < 16; k++) begin
            logic [11:0] dx;
            l1 = 12'(k * 251);
            case (k % 4)
                0: dx = 12'h001;
                1: dx = 12'h003;
                2: dx = 12'h0F0;
                default: dx = 12'h801;
            endcase
            cp = 24'h0F1E2D ^ 24'(k);
            send(cp ^ word_to_raw(loc_syndrome(l1) ^ loc_syndrome(l1 ^ dx)), cp,
                 3'd4, 9'd0, 3'd0, "R6 double bit");
        end

        // R5 R6: erased page and near misses.
        send(24'hFFFFFF, 24'h000000, 3'd3, 9'd0, 3'd0, "R5 erased");
        send(24'hFFFFFF, 24'h000001, 3'd4, 9'd0, 3'd0, "R6 not erased, computed nonzero");
        send(24'h000000, 24'hFFFFFF, 3'd4, 9'd0, 3'd0, "R6 reversed erased");
        send(24'hFFFFFE, 24'h000000, 3'd4, 9'd0, 3'd0, "R6 stored not all ones");

        // R9 R10: repair on a corrected result, loc 0x123 -> offset 0x24, bit 3.
        send(24'h000000 ^ word_to_raw(loc_syndrome(12'h123)), 24'h000000,
             3'd1, 9'h024, 3'd3, "R3 repair setup");
        idle();
        fix_offset = 9'h024; fix_byte_in = 8'hF0;
        #1 check(fix_byte_out == 8'hF8, "R9 flip", 32'(fix_byte_out), 32'hF8);
        fix_offset = 9'h025;
        #1 check(fix_byte_out == 8'hF0, "R10 offset mismatch", 32'(fix_byte_out), 32'hF0);

        // R8: hold while idle.
        repeat (3) @(negedge clk);
        check({res_status, res_byte_off, res_bit_idx} == {3'd1, 9'h024, 3'd3}, "R8 hold",
              32'({res_status, res_byte_off, res_bit_idx}), 32'({3'd1, 9'h024, 3'd3}));
        check(res_valid == 1'b0, "R7 valid one cycle", 32'(res_valid), 0);

        // Overlap: repair of old result while a clean request is accepted.
        fix_offset = 9'h024; fix_byte_in = 8'h00;
        send(24'h777777, 24'h777777, 3'd0, 9'd0, 3'd0, "R2 overlap clean");
        #1 check(fix_byte_out == 8'h08, "R9 before edge", 32'(fix_byte_out), 32'h08);
        idle();
        #1 check(fix_byte_out == 8'h00, "R10 after clean", 32'(fix_byte_out), 32'h00);

        // R10: corrected status but not on another result.
        send(24'hFFFFFF, 24'h000000, 3'd3, 9'd0, 3'd0, "R5 erased again");
        idle();
        fix_offset = 9'h000; fix_byte_in = 8'h3C;
        #1 check(fix_byte_out == 8'h3C, "R10 erased pass", 32'(fix_byte_out), 32'h3C);

        // R11: reset mid-run clears a corrected result.
        send(word_to_raw(loc_syndrome(12'hFFF)), 24'h000000, 3'd1, 9'h1FF, 3'd7, "R3 top location");
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(res_status == 3'd0, "R11 status cleared", 32'(res_status), 0);
        check({res_byte_off, res_bit_idx} == 12'd0, "R11 location cleared",
              32'({res_byte_off, res_bit_idx}), 0);
        check(res_valid == 1'b0, "R11 valid cleared", 32'(res_valid), 0);
        rst_n = 1'b1;

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7 results missing", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule